// File: doc/BRIEF.md
# Packed Decimal to Binary Converter

This block takes a signed decimal number stored two digits per byte and turns it into a 128-bit two's complement integer. A conversion starts with a one-cycle start pulse that carries the digit count, a value from 0 to 31. Bytes then arrive one per accepted handshake, with the most significant byte first. Every byte holds two 4-bit digit fields. The only exception is the low field of the final byte, which holds the sign code. When the digit count is even, the string carries one extra leading field that must be zero.

The block works out from the digit count how many bytes to accept. It raises its ready output only while bytes are still owed. It builds the magnitude by repeated multiply-by-ten and applies the sign at the end. A one-cycle done pulse then presents the result together with an error flag. Nothing inside the block deals with memory addresses. The caller streams the bytes in from wherever they are stored.

Top module: `pdec_to_bin`

## Requirements
- R1: After a start with digit count L, exactly L/2+1 bytes (integer division) are accepted. `byteReady` is high only while the conversion is running and bytes are still owed, and it is low once the last byte has been accepted.
- R2: The digit fields are consumed in arrival order. In each byte the high field (bits 7:4) comes before the low field (bits 3:0). The magnitude is the decimal number they form, with the first field the most significant.
- R3: Sign codes 4'hA, 4'hC, 4'hE and 4'hF give a non-negative result. Sign codes 4'hB and 4'hD give the negated magnitude. A negative zero gives 0.
- R4: A sign code of 4'h0 to 4'h9 sets `errFlag` for that conversion.
- R5: A digit field greater than 9 sets `errFlag`. The conversion still accepts the full L/2+1 bytes before `donePulse`.
- R6: When L is even, the high field of the first byte is padding. It adds nothing to the value, and if it is nonzero `errFlag` is set.
- R7: With L = 0, one byte is accepted. That byte holds the padding field and the sign code, and the result is 0.
- R8: `donePulse` is high for exactly one cycle, the cycle after the final byte is accepted. `result` and `errFlag` change only together with `donePulse`, and they hold their values until the next conversion completes.
- R9: A start pulse that arrives while a conversion is running is ignored. The running conversion's byte count and result are unaffected.
- R10: During and straight after reset, `byteReady`, `donePulse`, `errFlag` and `result` are all zero.
- R11: When `errFlag` is reported, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | One-cycle request to begin a conversion |
| digitCount | input | 5 | Number of decimal digits, 0 to 31, sampled with startIn |
| byteData | input | 8 | Packed byte, high field first |
| byteValid | input | 1 | byteData is valid |
| byteReady | output | 1 | Block accepts a byte this cycle |
| result | output | 128 | Signed binary result |
| donePulse | output | 1 | One-cycle completion strobe |
| errFlag | output | 1 | Malformed digit, padding or sign in the last conversion |

## Verification
The checker assumes that the upstream side respects the handshake. A byte counts as taken only in a cycle where both `byteValid` and `byteReady` are high. The checker also assumes `startIn` is a pulse, so it treats a start seen while idle as the beginning of a conversion. The bench raises `byteValid` only after sampling `byteReady` high on a falling edge. It inserts random idle gaps between bytes, and it pulses start mid-run only to exercise the ignore rule. Once the last byte is accepted, the bench holds `byteValid` high with junk data to show that no extra byte is taken.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  typedef struct packed {
    logic clear;    // new conversion begins
    logic take;     // a byte is accepted this cycle
    logic first;    // accepted byte is the first of the string
    logic last;     // accepted byte is the final one (carries sign)
    logic padEven;  // digit count is even: first high field is padding
  } pdecStrobe_t;

  localparam logic [3:0] SIGN_NEG_B = 4'hB;
  localparam logic [3:0] SIGN_NEG_D = 4'hD;
endpackage

// File: rtl/pdec_ctrl.sv
module pdec_ctrl #(
  parameter int MAX_DIGITS = 31,
  localparam int DIG_W = $clog2(MAX_DIGITS + 1),
  localparam int CNT_W = $clog2(MAX_DIGITS / 2 + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [DIG_W-1:0]   digitCount,
  input  logic               byteValid,
  output logic               byteReady,
  output logic               donePulse,
  output pdec_pkg::pdecStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] bytesLeft;
  logic             firstByte;
  logic             evenCount;
  logic [CNT_W-1:0] byteTotal;

  assign byteTotal = CNT_W'(digitCount >> 1) + CNT_W'(1);

  always_comb begin
    strobe.clear   = (state == ST_IDLE) && startIn;
    strobe.take    = (state == ST_RUN) && byteValid;
    strobe.first   = firstByte;
    strobe.last    = (bytesLeft == CNT_W'(1));
    strobe.padEven = evenCount;
  end

  assign byteReady = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bytesLeft <= '0;
      firstByte <= 1'b0;
      evenCount <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      if (strobe.clear) begin
        state     <= ST_RUN;
        bytesLeft <= byteTotal;
        firstByte <= 1'b1;
        evenCount <= ~digitCount[0];
      end else if (strobe.take) begin
        firstByte <= 1'b0;
        bytesLeft <= bytesLeft - CNT_W'(1);
        if (strobe.last) begin
          state     <= ST_IDLE;
          donePulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pdec_datapath.sv
module pdec_datapath #(
  parameter int RES_W = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pdec_pkg::pdecStrobe_t strobe,
  input  logic [7:0]            byteData,
  output logic [RES_W-1:0]      result,
  output logic                  errFlag
);
  import pdec_pkg::*;

  logic [RES_W-1:0] acc;
  logic             errAcc;
  logic [3:0]       hiNib, loNib;
  logic             isPad, hiBad, loBad, negSign, errNext;
  logic [RES_W-1:0] accHi, accLo;

  function automatic logic [RES_W-1:0] times10Add(input logic [RES_W-1:0] x,
                                                  input logic [3:0] d);
    return (x << 3) + (x << 1) + {{(RES_W-4){1'b0}}, d};
  endfunction

  always_comb begin
    hiNib   = byteData[7:4];
    loNib   = byteData[3:0];
    isPad   = strobe.first && strobe.padEven;
    hiBad   = isPad ? (hiNib != 4'h0) : (hiNib > 4'd9);
    loBad   = strobe.last ? (loNib < 4'hA) : (loNib > 4'd9);
    accHi   = isPad ? acc : times10Add(acc, hiNib);
    accLo   = times10Add(accHi, loNib);
    negSign = (loNib == SIGN_NEG_B) || (loNib == SIGN_NEG_D);
    errNext = errAcc || hiBad || loBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      errAcc  <= 1'b0;
      result  <= '0;
      errFlag <= 1'b0;
    end else if (strobe.clear) begin
      acc    <= '0;
      errAcc <= 1'b0;
    end else if (strobe.take) begin
      if (strobe.last) begin
        errFlag <= errNext;
        if (errNext)      result <= '0;
        else if (negSign) result <= '0 - accHi;
        else              result <= accHi;
      end else begin
        acc    <= accLo;
        errAcc <= errNext;
      end
    end
  end
endmodule

// File: rtl/pdec_to_bin.sv
module pdec_to_bin #(
  parameter int MAX_DIGITS = 31,
  parameter int RES_W = 128,
  localparam int DIG_W = $clog2(MAX_DIGITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [DIG_W-1:0] digitCount,
  input  logic [7:0]       byteData,
  input  logic             byteValid,
  output logic             byteReady,
  output logic [RES_W-1:0] result,
  output logic             donePulse,
  output logic             errFlag
);
  pdec_pkg::pdecStrobe_t strobe;

  pdec_ctrl #(.MAX_DIGITS(MAX_DIGITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .digitCount(digitCount),
    .byteValid(byteValid), .byteReady(byteReady), .donePulse(donePulse),
    .strobe(strobe)
  );

  pdec_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .result(result), .errFlag(errFlag)
  );
endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
  parameter int MAX_DIGITS = 31,
  parameter int RES_W = 128,
  localparam int DIG_W = $clog2(MAX_DIGITS + 1),
  localparam int CNT_W = $clog2(MAX_DIGITS / 2 + 2) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [DIG_W-1:0] digitCount,
  input logic             byteValid,
  input logic             byteReady,
  input logic [RES_W-1:0] result,
  input logic             donePulse,
  input logic             errFlag
);
  logic             chkBusy;
  logic [CNT_W-1:0] chkNeed, chkGot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkBusy <= 1'b0;
      chkNeed <= '0;
      chkGot  <= '0;
    end else begin
      if (!chkBusy && startIn) begin
        chkBusy <= 1'b1;
        chkNeed <= CNT_W'(digitCount / 2) + CNT_W'(1);
        chkGot  <= '0;
      end else if (chkBusy && byteValid && byteReady) begin
        chkGot <= chkGot + CNT_W'(1);
      end
      if (donePulse) chkBusy <= 1'b0;
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R1
  ready_low_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !byteReady);
  // R1
  byte_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> chkGot == chkNeed);
  // R1
  no_extra_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkBusy && chkGot == chkNeed) |-> !byteReady);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(result) || !$stable(errFlag)) |-> donePulse);
  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && errFlag) |-> result == '0);
endmodule

bind pdec_to_bin pdec_checker #(.MAX_DIGITS(MAX_DIGITS), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .digitCount(digitCount),
  .byteValid(byteValid), .byteReady(byteReady), .result(result),
  .donePulse(donePulse), .errFlag(errFlag)
);

// File: tb/sim_pdec_to_bin.sv
module sim_pdec_to_bin;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [4:0]   digitCount = '0;
  logic [7:0]   byteData = '0;
  logic         byteValid = 1'b0;
  logic         byteReady, donePulse, errFlag;
  logic [127:0] result;

  int testsRun = 0, testsFailed = 0;
  logic [128:0] expQ[$];
  string        tagQ[$];
  logic [3:0]   nib[0:63];
  logic [127:0] lastRes;
  logic         lastErr;

  always #4 clk = ~clk;

  pdec_to_bin u0 (.clk(clk), .rstN(rstN), .startIn(startIn), .digitCount(digitCount),
    .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady),
    .result(result), .donePulse(donePulse), .errFlag(errFlag));

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && donePulse) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected done", 128'(1), 128'(0));
      end else begin
        logic [128:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(result == e[128:1], {t, " result"}, result, e[128:1]);
        check(errFlag == e[0], {t, " errFlag"}, 128'(errFlag), 128'(e[0]));
        lastRes = result;
        lastErr = errFlag;
      end
    end
  end

  task automatic conv(input int L, input logic [3:0] sgn, input logic [3:0] pad,
                      input int badPos, input bit midStart, input string tag);
    logic signed [127:0] v;
    bit bad;
    int k, nb;
    v = 0; bad = 0; k = 0; nb = L / 2 + 1;
    if (L % 2 == 0) begin nib[k] = pad; k++; if (pad != 0) bad = 1; end
    for (int i = 0; i < L; i++) begin
      logic [3:0] d;
      d = 4'($urandom % 10);
      if (i == badPos) d = 4'(10 + $urandom % 6);
      nib[k] = d; k++;
      if (d > 9) bad = 1; else v = v * 10 + 128'(d);
    end
    nib[k] = sgn;
    if (sgn < 4'hA) bad = 1;
    if (sgn == 4'hB || sgn == 4'hD) v = -v;
    if (bad) v = 0;
    expQ.push_back({v, bad});
    tagQ.push_back(tag);
    @(negedge clk); startIn = 1'b1; digitCount = 5'(L);
    @(negedge clk); startIn = 1'b0;
    for (int b = 0; b < nb; b++) begin
      forever begin
        if (midStart && b == 1) begin startIn = 1'b1; digitCount = ~5'(L); end
        if ($urandom % 4 == 0 || !byteReady) begin
          byteValid = 1'b0;
          @(negedge clk);
          startIn = 1'b0;
        end else begin
          byteValid = 1'b1;
          byteData = {nib[2*b], nib[2*b+1]};
          @(negedge clk);
          startIn = 1'b0;
          break;
        end
      end
    end
    // R1: no further byte is requested after the last
    byteValid = 1'b1; byteData = 8'hFF;
    check(byteReady == 1'b0, "R1 ready low after last byte", 128'(byteReady), 0);
    @(negedge clk);
    check(byteReady == 1'b0, "R1 ready stays low", 128'(byteReady), 0);
    byteValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(byteReady == 0 && donePulse == 0, "R10 control outputs in reset",
          128'({byteReady, donePulse}), 0);
    check(result == 0 && errFlag == 0, "R10 data outputs in reset", result, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(byteReady == 0, "R10 idle after reset", 128'(byteReady), 0);

    conv(31, 4'hC, 4'h0, -1, 0, "R2 31 digits positive");
    conv(30, 4'hD, 4'h0, -1, 0, "R3 even count negative D");
    conv(5,  4'hB, 4'h0, -1, 0, "R3 odd count negative B");
    conv(3,  4'hA, 4'h0, -1, 0, "R3 sign A");
    conv(4,  4'hE, 4'h0, -1, 0, "R3 sign E");
    conv(1,  4'hF, 4'h0, -1, 0, "R3 sign F");
    conv(0,  4'hD, 4'h0, -1, 0, "R7 zero digits negative zero");
    conv(0,  4'hC, 4'h0, -1, 0, "R7 zero digits");
    conv(7,  4'h3, 4'h0, -1, 0, "R4 digit as sign");
    conv(6,  4'hC, 4'h0, 2,  0, "R5 bad digit");
    conv(9,  4'hD, 4'h0, 8,  0, "R5 bad last digit");
    conv(8,  4'hC, 4'h5, -1, 0, "R6 nonzero pad");
    conv(0,  4'hC, 4'h1, -1, 0, "R6 R7 pad in sign byte");
    conv(12, 4'hC, 4'h0, -1, 1, "R9 start during run");
    conv(5,  4'hC, 4'h0, 0,  0, "R11 error gives zero");
    repeat (4) @(negedge clk);
    // R8 hold after done
    check(result == lastRes && errFlag == lastErr, "R8 result held", result, lastRes);
    for (int n = 0; n < 40; n++) begin
      int L, bp;
      logic [3:0] s;
      L = $urandom % 32;
      s = 4'hA + 4'($urandom % 6);
      bp = ($urandom % 5 == 0) ? int'($urandom % 32) : -1;
      conv(L, s, 4'h0, bp, 0, "R2 random");
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 all conversions completed", 128'(expQ.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule